// File: doc/BRIEF.md
# Multicore Coherency Unit Register Block

This block holds the software-visible registers of a snoop control unit that serves a cluster of one to four processors. A simple synchronous request bus carries an offset, a byte count, a write strobe and write data. Read data comes back on a registered response one clock after the request. The block decodes a 256-byte window. In that window sit three live registers, a handful of reserved offsets, and a range of undecoded offsets.

The three live registers are a one-bit enable, a read-only identity word built from the `NUM_CORES` parameter, and a 32-bit power-status word. The power-status word can be written and read at any of its four byte offsets. A write at a byte offset changes only the lanes that the access size covers from that offset upward. A read at a byte offset returns the word moved down to that byte.

A write whose size is not 1, 2 or 4 bytes changes no register and raises a sticky error flag. The block has two resets. The power-on reset `rst_n` clears every register. The device reset `dev_rst` clears only the enable bit.

Top module: `coh_regblock`

## Requirements
- R1: While `rst_n` is low, `ctrl_en`, `pwr_status`, `size_err`, `rsp_valid` and `rsp_rdata` are all zero.
- R2: A write of valid size to offset 0x00 stores bit 0 of the write data in `ctrl_en` and ignores the other bits. A read of 0x00 returns `ctrl_en` in bit 0 and zero in bits 31:1.
- R3: A read of offset 0x04 returns (`NUM_CORES`−1) in bits 1:0 and `NUM_CORES` ones starting at bit 4; every other bit is zero. Writes to 0x04 change nothing.
- R4: A write of valid size S bytes to offset 0x08+k (k = 0..3) replaces byte lanes k up to k+S−1 of `pwr_status` with write-data bytes 0 up to S−1. Lanes above lane 3 are dropped, and every other lane keeps its value.
- R5: A read at offset 0x08+k returns `pwr_status` shifted right by 8·k bits, with zeros filled in from the top.
- R6: Offsets 0x0C, 0x40, 0x44, 0x50, 0x54 and every other offset not named in R2–R5 read as zero. Writes to them leave `ctrl_en` and `pwr_status` unchanged.
- R7: A write whose `req_size` is not 1, 2 or 4 changes neither `ctrl_en` nor `pwr_status`. It sets `size_err`, which stays set until `rst_n` is asserted.
- R8: `dev_rst` high at a clock edge clears `ctrl_en` and wins over a write to 0x00 in the same cycle. It leaves `pwr_status` and `size_err` unchanged.
- R9: A read request at one edge gives `rsp_valid` high with the read data after that edge. Writes and idle cycles give `rsp_valid` low and `rsp_rdata` zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous; clears all state |
| dev_rst | input | 1 | Device reset, active high, synchronous; clears the enable bit only |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the window |
| req_size | input | 3 | Access size in bytes; 1, 2 and 4 are valid |
| req_wdata | input | 32 | Write data, least significant byte in lane 0 |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| ctrl_en | output | 1 | Stored enable bit |
| pwr_status | output | 32 | Power-status word |
| size_err | output | 1 | Sticky flag for a write with an invalid size |

## Verification
The bench builds the block with `NUM_CORES` = 3. Three is not a power of two, so the identity word shows a field of three ones above a count field of 2, and a wrong field width or an off-by-one count shows up at once. `ADDR_W` stays at 8, so the full 256-byte window is reachable, including the top offset 0xFC. The bench drives writes of every size at every status byte offset, including 2- and 4-byte writes at lane 3 where bytes run past bit 31. It also drives device resets that land in the same cycle as an enable write, and writes with sizes 0, 3 and 7.

// File: rtl/coh_pkg.sv
package coh_pkg;

  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_CFG  = 8'h04;
  localparam logic [7:0] OFF_STAT = 8'h08;

  typedef struct packed {
    logic       ctrl;
    logic       cfg;
    logic       stat;
    logic [1:0] lane;
  } sel_t;

  // Byte-lane mask for a given access size; zero for an unsupported size.
  function automatic logic [DATA_W-1:0] size_mask(input logic [2:0] sz);
    case (sz)
      3'd1:    return 32'h0000_00FF;
      3'd2:    return 32'h0000_FFFF;
      3'd4:    return 32'hFFFF_FFFF;
      default: return '0;
    endcase
  endfunction

  function automatic logic size_ok(input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

  // Identity word: count-1 in the low bits, one set bit per core from bit 4.
  function automatic logic [DATA_W-1:0] cfg_word(input int n);
    logic [DATA_W-1:0] w;
    w = '0;
    for (int i = 0; i < 4; i++) begin
      if (i < n) w[4+i] = 1'b1;
    end
    w[1:0] = 2'(n - 1);
    return w;
  endfunction

  // Replace the masked lanes starting at lane; bits moved past the top are lost.
  function automatic logic [DATA_W-1:0] lane_merge(
      input logic [DATA_W-1:0] old,
      input logic [DATA_W-1:0] wd,
      input logic [DATA_W-1:0] m,
      input logic [1:0]        lane);
    logic [4:0]        sh;
    logic [DATA_W-1:0] pm;
    logic [DATA_W-1:0] pd;
    sh = {lane, 3'b000};
    pm = m << sh;
    pd = (wd & m) << sh;
    return (old & ~pm) | pd;
  endfunction

  function automatic logic [DATA_W-1:0] lane_view(
      input logic [DATA_W-1:0] w,
      input logic [1:0]        lane);
    return w >> {lane, 3'b000};
  endfunction

endpackage

// File: rtl/coh_decode.sv
module coh_decode
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_t              sel
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);

  always_comb begin
    sel.ctrl = (addr == A_CTRL);
    sel.cfg  = (addr == A_CFG);
    sel.stat = (addr[ADDR_W-1:2] == A_STAT[ADDR_W-1:2]);
    sel.lane = addr[1:0];
  end
endmodule

// File: rtl/coh_status_reg.sv
module coh_status_reg
  import coh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        lane,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] status
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     status <= '0;
    else if (wr_en) status <= lane_merge(status, wdata, mask, lane);
  end

  // R4: lane 0 is never touched by a write that starts above it
  a_r4_low_lane_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lane != 2'd0) |=> status[7:0] == $past(status[7:0]));
endmodule

// File: rtl/coh_ctrl_reg.sv
module coh_ctrl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic dev_rst,
  input  logic wr_ctrl,
  input  logic wbit,
  input  logic bad_wr,
  output logic ctrl_en,
  output logic size_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en  <= 1'b0;
      size_err <= 1'b0;
    end else begin
      if (dev_rst)      ctrl_en <= 1'b0;
      else if (wr_ctrl) ctrl_en <= wbit;
      if (bad_wr)       size_err <= 1'b1;
    end
  end

  a_r8_dev_rst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst |=> !ctrl_en);
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |=> size_err);
endmodule

// File: rtl/coh_regblock.sv
module coh_regblock
  import coh_pkg::*;
#(
  parameter int NUM_CORES = 1,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_rst,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              ctrl_en,
  output logic [31:0]       pwr_status,
  output logic              size_err
);
  localparam logic [DATA_W-1:0] CFG_VALUE = cfg_word(NUM_CORES);

  sel_t              sel;
  logic              is_read;
  logic              wr_ok;
  logic              bad_wr;
  logic              wr_ctrl;
  logic              wr_stat;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] rd_mux;

  coh_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (req_addr),
    .sel  (sel)
  );

  assign mask    = size_mask(req_size);
  assign is_read = req_valid && !req_we;
  assign wr_ok   = req_valid && req_we && size_ok(req_size);
  assign bad_wr  = req_valid && req_we && !size_ok(req_size);
  assign wr_ctrl = wr_ok && sel.ctrl;
  assign wr_stat = wr_ok && sel.stat;

  coh_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_rst  (dev_rst),
    .wr_ctrl  (wr_ctrl),
    .wbit     (req_wdata[0]),
    .bad_wr   (bad_wr),
    .ctrl_en  (ctrl_en),
    .size_err (size_err)
  );

  coh_status_reg u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_stat),
    .lane   (sel.lane),
    .mask   (mask),
    .wdata  (req_wdata),
    .status (pwr_status)
  );

  always_comb begin
    rd_mux = '0;
    if (sel.ctrl)      rd_mux = {{(DATA_W-1){1'b0}}, ctrl_en};
    else if (sel.cfg)  rd_mux = CFG_VALUE;
    else if (sel.stat) rd_mux = lane_view(pwr_status, sel.lane);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= is_read;
      rsp_rdata <= is_read ? rd_mux : '0;
    end
  end

  a_r6_decode_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel.ctrl, sel.cfg, sel.stat}));
  a_r6_status_only_by_own_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> $stable(pwr_status));
  a_r7_bad_write_discarded: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_wr && !dev_rst) |=> $stable(pwr_status) && $stable(ctrl_en));
  a_r7_err_needs_bad_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(size_err) |-> $past(bad_wr));
  a_r2_enable_rise_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_en) |-> $past(wr_ctrl && req_wdata[0]));
  a_r9_response_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    is_read |=> rsp_valid);
  a_r9_quiet_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    !is_read |=> !rsp_valid && rsp_rdata == '0);
endmodule

// File: tb/coh_regblock_bench.sv
module coh_regblock_bench;
  localparam int NC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dev_rst = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [2:0]  req_size = 3'd4;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        ctrl_en;
  logic [31:0] pwr_status;
  logic        size_err;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  bit          m_ctrl;
  logic [31:0] m_status;
  bit          m_err;
  bit          m_rv;
  logic [31:0] m_rd;

  always #5 clk = ~clk;

  coh_regblock #(.NUM_CORES(NC), .ADDR_W(8)) u_coh_regblock (
    .clk(clk), .rst_n(rst_n), .dev_rst(dev_rst),
    .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ctrl_en(ctrl_en), .pwr_status(pwr_status), .size_err(size_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] ident(input int n);
    return (((32'd1 << n) - 32'd1) << 4) + 32'(n - 1);
  endfunction

  // Behavioural model, updated on each rising edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_status = 0; m_err = 0; m_rv = 0; m_rd = 0;
    end else begin
      int a;
      int sz;
      a = int'(req_addr);
      sz = int'(req_size);
      m_rv = req_valid && !req_we;
      m_rd = 0;
      if (m_rv) begin
        if (a == 0) m_rd = {31'd0, m_ctrl};
        else if (a == 4) m_rd = ident(NC);
        else if (a >= 8 && a <= 11) m_rd = m_status >> (8 * (a - 8));
      end
      if (req_valid && req_we) begin
        if (sz != 1 && sz != 2 && sz != 4) m_err = 1;
        else if (a == 0) m_ctrl = req_wdata[0];
        else if (a >= 8 && a <= 11) begin
          for (int b = 0; b < sz; b++) begin
            int pos;
            pos = a - 8 + b;
            if (pos < 4) m_status[pos*8 +: 8] = req_wdata[b*8 +: 8];
          end
        end
      end
      if (dev_rst) m_ctrl = 0;
    end
  end

  // Compare every cycle, away from the rising edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 ctrl_en", {31'd0, ctrl_en}, {31'd0, m_ctrl});
      check("R4 pwr_status", pwr_status, m_status);
      check("R7 size_err", {31'd0, size_err}, {31'd0, m_err});
      check("R9 rsp_valid", {31'd0, rsp_valid}, {31'd0, m_rv});
      check("R5 rsp_rdata", rsp_rdata, m_rd);
    end
  end

  task automatic drive(input bit v, input bit we, input logic [7:0] a,
                       input logic [2:0] sz, input logic [31:0] wd);
    @(negedge clk);
    req_valid = v; req_we = we; req_addr = a; req_size = sz; req_wdata = wd;
  endtask

  task automatic idle();
    drive(0, 0, 8'h00, 3'd4, 32'h0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] wd);
    drive(1, 1, a, sz, wd);
    idle();
  endtask

  task automatic rd_expect(input string tag, input logic [7:0] a, input logic [31:0] exp);
    drive(1, 0, a, 3'd4, 32'h0);
    idle();
    check(tag, rsp_rdata, exp);
    check(tag, {31'd0, rsp_valid}, 32'd1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: everything zero while held in reset
    check("R1 ctrl_en", {31'd0, ctrl_en}, 32'd0);
    check("R1 pwr_status", pwr_status, 32'd0);
    check("R1 size_err", {31'd0, size_err}, 32'd0);
    check("R1 rsp", {31'd0, rsp_valid} | rsp_rdata, 32'd0);
    rst_n = 1'b1;
    idle();

    // R3: identity word for three cores is 0x72, writes ignored
    rd_expect("R3 identity", 8'h04, 32'h0000_0072);
    wr(8'h04, 3'd4, 32'hFFFF_FFFF);
    rd_expect("R3 identity after write", 8'h04, 32'h0000_0072);

    // R2: only bit 0 kept
    wr(8'h00, 3'd4, 32'hFFFF_FFFF);
    rd_expect("R2 enable set", 8'h00, 32'h1);
    wr(8'h00, 3'd1, 32'h0000_0002);
    rd_expect("R2 enable cleared by bit0=0", 8'h00, 32'h0);

    // R4: lane-masked writes at each offset
    wr(8'h08, 3'd4, 32'h1122_3344);
    wr(8'h09, 3'd1, 32'hFFFF_FFAB);
    check("R4 byte at lane1", pwr_status, 32'h1122_AB44);
    wr(8'h0A, 3'd2, 32'h9999_CDEF);
    check("R4 half at lane2", pwr_status, 32'hCDEF_AB44);
    wr(8'h0B, 3'd4, 32'h5566_7788);
    check("R4 word at lane3 truncated", pwr_status, 32'h88EF_AB44);
    wr(8'h0B, 3'd2, 32'h0000_1234);
    check("R4 half at lane3 truncated", pwr_status, 32'h34EF_AB44);

    // R5: shifted views
    rd_expect("R5 view lane0", 8'h08, 32'h34EF_AB44);
    rd_expect("R5 view lane1", 8'h09, 32'h0034_EFAB);
    rd_expect("R5 view lane2", 8'h0A, 32'h0000_34EF);
    rd_expect("R5 view lane3", 8'h0B, 32'h0000_0034);

    // R6: reserved and undecoded offsets
    wr(8'h00, 3'd4, 32'h1);
    foreach (rsv_list[i]) begin
      wr(rsv_list[i], 3'd4, 32'hFFFF_FFFF);
      rd_expect("R6 reads zero", rsv_list[i], 32'h0);
    end
    check("R6 status untouched", pwr_status, 32'h34EF_AB44);
    check("R6 enable untouched", {31'd0, ctrl_en}, 32'd1);

    // R7: invalid sizes are discarded and latch the flag
    wr(8'h08, 3'd3, 32'h0);
    check("R7 status kept size3", pwr_status, 32'h34EF_AB44);
    check("R7 flag set", {31'd0, size_err}, 32'd1);
    wr(8'h00, 3'd0, 32'h0);
    check("R7 enable kept size0", {31'd0, ctrl_en}, 32'd1);
    wr(8'h09, 3'd7, 32'h0);
    wr(8'h08, 3'd1, 32'h0000_0011);
    check("R7 flag sticky", {31'd0, size_err}, 32'd1);

    // R8: device reset clears only the enable, and wins over a same-cycle write
    @(negedge clk); dev_rst = 1'b1;
    @(negedge clk); dev_rst = 1'b0;
    check("R8 enable cleared", {31'd0, ctrl_en}, 32'd0);
    check("R8 status kept", pwr_status, 32'h34EF_AB11);
    check("R8 flag kept", {31'd0, size_err}, 32'd1);
    drive(1, 1, 8'h00, 3'd4, 32'h1); dev_rst = 1'b1;
    idle(); dev_rst = 1'b0;
    check("R8 wins over write", {31'd0, ctrl_en}, 32'd0);

    // R9: idle cycle gives no response
    idle();
    check("R9 idle", {31'd0, rsp_valid}, 32'd0);

    // Mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic [2:0] sz;
      int pick;
      pick = int'($urandom_range(0, 9));
      a = (pick < 7) ? 8'($urandom_range(0, 15)) : 8'($urandom);
      sz = ($urandom_range(0, 7) == 0) ? 3'($urandom) : ((pick % 3 == 0) ? 3'd1 : (pick % 3 == 1) ? 3'd2 : 3'd4);
      drive($urandom_range(0, 3) != 0, 1'($urandom), a, sz, $urandom);
      dev_rst = ($urandom_range(0, 15) == 0);
    end
    idle(); dev_rst = 1'b0;
    idle();

    // R1: power-on reset clears status and flag as well
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 status after reset", pwr_status, 32'h0);
    check("R1 flag after reset", {31'd0, size_err}, 32'h0);
    rst_n = 1'b1;
    idle(); idle();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  logic [7:0] rsv_list [6] = '{8'h0C, 8'h40, 8'h44, 8'h50, 8'h54, 8'hFC};

endmodule